// File: doc/BRIEF.md
# Byte-Access Sample FIFO with Fill Threshold

This block sits between an analog conversion path and a host with a byte-wide bus. Each strobe on `smp_valid_i` delivers a 16-bit result, and the block stores it in a FIFO that is 4096 entries deep by default. The host reads the FIFO through an 8-bit data address, which needs two reads per sample. The host also reads a status byte, and writes a small control byte, through a second address.

The fill threshold is programmed through the data address. After a FIFO reset, the block counts the byte writes made to that address. The first two bytes are ignored. The third and fourth bytes are the low and high bytes of a free-space value, which is the depth minus the wanted threshold. Any later writes are ignored until the next reset.

Three conditions are latched as events: threshold reached, data lost and end of scan. These events drive an interrupt request, which is gated by two enable bits. Reading the status byte clears the latched events.

Top module: `smp_byte_fifo`

## Requirements
- R1: After `rst_ni` is released with `running_i` low, the status byte reads 0x81 (idle and empty), `rdata_o` is 0x00 and `irq_o` is low.
- R2: Samples leave the FIFO in arrival order. A data read (`addr_i`=0) returns the low byte of the oldest sample first, and the next data read returns its high byte and removes the sample.
- R3: A data read while the FIFO is empty returns 0x00 and does not advance the byte phase.
- R4: A sample that arrives while the FIFO holds DEPTH samples is dropped, and status bit 5 (data lost) is set.
- R5: Status bit 2 is set when the FIFO holds DEPTH samples. Bit 1 is set when it holds at least DEPTH-NEAR_GAP samples. Bit 0 is set when it holds none.
- R6: After a FIFO reset, data writes 1 and 2 are ignored, write 3 loads the low byte and write 4 the high byte of the free value F, and later writes are ignored. Status bit 3 latches once count + F >= DEPTH.
- R7: A status read returns the status byte as it stood before the read, then clears the latched events (bits 5, 4 and 3). An event raised in the same cycle as the read is kept. Bit 3 is set again as long as its condition holds.
- R8: A pulse on `eos_i` sets status bit 4.
- R9: A write to `addr_i`=1 sets the control byte. Bit 3 enables the interrupt for threshold and data lost, and bit 4 enables it for end of scan. `irq_o` is high while any enabled event is latched.
- R10: A `fifo_clr_i` pulse empties the FIFO, clears data lost and the threshold event, returns the byte phase to the low byte, and restarts the threshold write sequence.
- R11: Status bit 6 follows `running_i`, and bit 7 is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 16 | Sample value |
| eos_i | input | 1 | End-of-scan pulse |
| running_i | input | 1 | Acquisition running indication |
| fifo_clr_i | input | 1 | FIFO reset pulse |
| addr_i | input | 1 | 0 = data, 1 = status (read) / control (write) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Registered read byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A read byte is captured at the clock edge that samples `rd_i`, so the bench checks `rdata_o` at the falling edge that follows. Pushes, pops and the data-lost flag update at that same edge. The threshold event is latched one edge after the count changes, and `irq_o` then follows the latched events combinationally. For this reason the bench inserts one idle cycle before every status read and every interrupt check, which lets the one-edge latency of the threshold event settle. The expected values come from a queue model of the FIFO with sticky event flags.

// File: rtl/smpf_pkg.sv
`timescale 1ns/1ps
package smpf_pkg;
  localparam int unsigned SMP_W = 16;
  // status byte bit positions
  localparam int unsigned ST_EMPTY = 0;
  localparam int unsigned ST_NEAR  = 1;
  localparam int unsigned ST_FULL  = 2;
  localparam int unsigned ST_THR   = 3;
  localparam int unsigned ST_EOS   = 4;
  localparam int unsigned ST_LOST  = 5;
  localparam int unsigned ST_RUN   = 6;
  localparam int unsigned ST_IDLE  = 7;
  // control byte bit positions
  localparam int unsigned CT_FIFO_IE = 3;
  localparam int unsigned CT_EOS_IE  = 4;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
endpackage

// File: rtl/smpf_store.sv
`timescale 1ns/1ps
module smpf_store #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push_i && (count_o != CW'(DEPTH));
  assign do_pop  = pop_i && (count_o != '0);
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R4
  drop_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clr_i && count_o == CW'(DEPTH)) |=> count_o == CW'(DEPTH));
endmodule

// File: rtl/smpf_thresh.sv
`timescale 1ns/1ps
module smpf_thresh #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned CW    = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic [CW-1:0] count_i,
  output logic          hit_o
);
  logic [2:0]  idx_q;
  logic [15:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      free_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (wr_i && idx_q != 3'd4) begin
      idx_q <= idx_q + 3'd1;
      if (idx_q == 3'd2) free_q[7:0]  <= wdata_i;
      if (idx_q == 3'd3) free_q[15:8] <= wdata_i;
    end
  end

  assign hit_o = (32'(count_i) + 32'(free_q)) >= 32'(DEPTH);

  // R6
  load_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == 3'd4 && !clr_i) |=> $stable(free_q));
endmodule

// File: rtl/smpf_events.sv
`timescale 1ns/1ps
module smpf_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic thr_hit_i,
  input  logic lost_set_i,
  input  logic eos_i,
  input  logic stat_rd_i,
  input  logic fifo_ie_i,
  input  logic eos_ie_i,
  output logic thr_o,
  output logic lost_o,
  output logic eos_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o  <= 1'b0;
      lost_o <= 1'b0;
      eos_o  <= 1'b0;
    end else begin
      // events raised during a status read survive it
      eos_o <= (eos_o && !stat_rd_i) || eos_i;
      if (clr_i) begin
        thr_o  <= 1'b0;
        lost_o <= 1'b0;
      end else begin
        thr_o  <= (thr_o && !stat_rd_i) || thr_hit_i;
        lost_o <= (lost_o && !stat_rd_i) || lost_set_i;
      end
    end
  end

  assign irq_o = (fifo_ie_i && (thr_o || lost_o)) || (eos_ie_i && eos_o);

  // R7
  eos_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !eos_i) |=> !eos_o);
  // R7
  eos_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i |=> eos_o);
  // R4
  lost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_set_i && !clr_i) |=> lost_o);
endmodule

// File: rtl/smp_byte_fifo.sv
`timescale 1ns/1ps
module smp_byte_fifo
  import smpf_pkg::*;
#(
  parameter int unsigned DEPTH    = 4096,
  parameter int unsigned NEAR_GAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             eos_i,
  input  logic             running_i,
  input  logic             fifo_clr_i,
  input  logic             addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    count;
  logic [SMP_W-1:0] head;
  logic             data_rd, stat_rd, data_wr, ctrl_wr;
  logic             empty, full, near, pop;
  logic             thr_hit, thr_evt, lost_evt, eos_evt;
  logic             fifo_ie_q, eos_ie_q;
  phase_e           phase_q;
  logic [7:0]       status;

  assign data_rd = rd_i && !addr_i;
  assign stat_rd = rd_i && addr_i;
  assign data_wr = wr_i && !addr_i;
  assign ctrl_wr = wr_i && addr_i;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign near    = (count >= CW'(DEPTH - NEAR_GAP));
  assign pop     = data_rd && !empty && (phase_q == PH_HI);

  smpf_store #(.DEPTH(DEPTH), .DW(SMP_W), .CW(CW)) u_store (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .push_i(smp_valid_i), .din_i(smp_data_i),
    .pop_i(pop), .dout_o(head), .count_o(count)
  );

  smpf_thresh #(.DEPTH(DEPTH), .CW(CW)) u_thresh (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .wr_i(data_wr), .wdata_i,
    .count_i(count), .hit_o(thr_hit)
  );

  smpf_events u_events (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .thr_hit_i(thr_hit),
    .lost_set_i(smp_valid_i && full), .eos_i, .stat_rd_i(stat_rd),
    .fifo_ie_i(fifo_ie_q), .eos_ie_i(eos_ie_q),
    .thr_o(thr_evt), .lost_o(lost_evt), .eos_o(eos_evt), .irq_o
  );

  always_comb begin
    status           = '0;
    status[ST_IDLE]  = !running_i;
    status[ST_RUN]   = running_i;
    status[ST_LOST]  = lost_evt;
    status[ST_EOS]   = eos_evt;
    status[ST_THR]   = thr_evt;
    status[ST_FULL]  = full;
    status[ST_NEAR]  = near;
    status[ST_EMPTY] = empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_ie_q <= 1'b0;
      eos_ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      fifo_ie_q <= wdata_i[CT_FIFO_IE];
      eos_ie_q  <= wdata_i[CT_EOS_IE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LO;
    end else if (fifo_clr_i) begin
      phase_q <= PH_LO;
    end else if (data_rd && !empty) begin
      phase_q <= (phase_q == PH_LO) ? PH_HI : PH_LO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (stat_rd) begin
      rdata_o <= status;
    end else if (data_rd) begin
      if (empty)                rdata_o <= 8'h00;
      else if (phase_q == PH_LO) rdata_o <= head[7:0];
      else                       rdata_o <= head[15:8];
    end
  end

  // R3
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && empty && !fifo_clr_i) |=> (rdata_o == 8'h00) && $stable(phase_q));
  // R10
  clr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (count == '0) && (phase_q == PH_LO) && !lost_evt);
  // R2
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !empty && phase_q == PH_LO && !fifo_clr_i) |=> (phase_q == PH_HI) && $stable(count));
endmodule

// File: tb/sim_smp_byte_fifo.sv
`timescale 1ns/1ps
module sim_smp_byte_fifo;
  localparam int DEPTH = 4096;
  localparam int NEAR_GAP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic eos_i = 1'b0, running_i = 1'b0, fifo_clr_i = 1'b0;
  logic addr_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic irq_o;

  always #2 clk = ~clk;

  smp_byte_fifo #(.DEPTH(DEPTH), .NEAR_GAP(NEAR_GAP)) u0 (
    .clk_i(clk), .rst_ni, .smp_valid_i, .smp_data_i, .eos_i, .running_i,
    .fifo_clr_i, .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o, .irq_o
  );

  int n_chk = 0, n_bad = 0;
  int q[$];
  bit m_lost, m_eos, m_thr, m_ph, m_fie, m_eie;
  int free_v = 0, ld_idx = 0;
  bit done = 0;

  function automatic bit thr_cond();
    return (q.size() + free_v) >= DEPTH;
  endfunction

  function automatic logic [7:0] exp_status();
    int n = q.size();
    return {!running_i, running_i, m_lost, m_eos, m_thr,
            n == DEPTH, n >= DEPTH - NEAR_GAP, n == 0};
  endfunction

  function automatic bit exp_irq();
    return (m_fie && (m_thr || m_lost)) || (m_eie && m_eos);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    if (thr_cond()) m_thr = 1;
  endtask

  task automatic push(int d);
    smp_valid_i = 1; smp_data_i = d[15:0];
    @(negedge clk);
    smp_valid_i = 0;
    if (q.size() < DEPTH) q.push_back(d & 16'hffff); else m_lost = 1;
    if (thr_cond()) m_thr = 1;
  endtask

  task automatic rd_data(string tag);
    int e;
    if (q.size() == 0) e = 0;
    else if (!m_ph) begin e = q[0] & 8'hff; m_ph = 1; end
    else begin e = (q[0] >> 8) & 8'hff; void'(q.pop_front()); m_ph = 0; end
    rd_i = 1; addr_i = 0;
    @(negedge clk);
    rd_i = 0;
    check(tag, rdata_o, e);
    if (thr_cond()) m_thr = 1;
  endtask

  task automatic rd_stat(string tag, bit eos_during);
    logic [7:0] e;
    idle();
    e = exp_status();
    rd_i = 1; addr_i = 1; eos_i = eos_during;
    @(negedge clk);
    rd_i = 0; addr_i = 0; eos_i = 0;
    check(tag, rdata_o, e);
    m_lost = 0; m_eos = eos_during; m_thr = thr_cond();
  endtask

  task automatic wr_data(int b);
    wr_i = 1; addr_i = 0; wdata_i = b[7:0];
    @(negedge clk);
    wr_i = 0;
    if (ld_idx == 2) free_v = (free_v & 16'hff00) | (b & 8'hff);
    if (ld_idx == 3) free_v = (free_v & 16'h00ff) | ((b & 8'hff) << 8);
    if (ld_idx < 4) ld_idx++;
  endtask

  task automatic wr_ctrl(int b);
    wr_i = 1; addr_i = 1; wdata_i = b[7:0];
    @(negedge clk);
    wr_i = 0; addr_i = 0;
    m_fie = b[3]; m_eie = b[4];
  endtask

  task automatic fifo_clr();
    fifo_clr_i = 1;
    @(negedge clk);
    fifo_clr_i = 0;
    q.delete(); m_ph = 0; m_lost = 0; m_thr = 0; ld_idx = 0;
  endtask

  task automatic chk_irq(string tag);
    idle();
    check(tag, irq_o, exp_irq());
  endtask

  initial begin
    int seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata_o, 0);
    check("R1 irq", irq_o, 0);
    rd_stat("R1 status", 0);

    // R2 random bursts
    for (int r = 0; r < 6; r++) begin
      int n = 1 + ($urandom % 40);
      for (int i = 0; i < n; i++) push($urandom);
      for (int i = 0; i < 2 * n; i++) rd_data("R2 order");
      rd_stat("R2 status empty", 0);
    end

    // R3 empty read then phase intact
    rd_data("R3 empty");
    rd_data("R3 empty again");
    push(16'hA55A);
    rd_data("R3 low after empty");
    rd_data("R3 high after empty");

    // R6 threshold load
    fifo_clr();
    wr_data(8'h11); wr_data(8'h22);
    wr_data((DEPTH - 10) & 8'hff); wr_data((DEPTH - 10) >> 8);
    wr_data(8'hff); wr_data(8'hff);
    for (int i = 0; i < 9; i++) push($urandom);
    rd_stat("R6 below", 0);
    push($urandom);
    rd_stat("R6 reached", 0);
    rd_stat("R7 thr relatch", 0);
    wr_ctrl(8'h08);
    chk_irq("R9 fifo irq");
    for (int i = 0; i < 20; i++) rd_data("R2 drain");
    rd_stat("R7 thr sticky", 0);
    rd_stat("R7 thr cleared", 0);
    chk_irq("R9 irq low");

    // R5 / R4 fill to full and overflow
    fifo_clr();
    wr_data(0); wr_data(0); wr_data(0); wr_data(0);
    for (int i = 0; i < DEPTH - NEAR_GAP - 1; i++) push($urandom);
    rd_stat("R5 below near", 0);
    push($urandom);
    rd_stat("R5 near", 0);
    while (q.size() < DEPTH) push($urandom);
    rd_stat("R5 full", 0);
    push(16'hDEAD);
    rd_stat("R4 lost", 0);
    push(16'hBEEF);
    chk_irq("R9 lost irq");
    for (int i = 0; i < 2 * DEPTH; i++) rd_data("R4 data kept");
    rd_stat("R5 empty", 0);

    // R8 / R7 end of scan
    wr_ctrl(8'h10);
    chk_irq("R9 no eos");
    eos_i = 1; @(negedge clk); eos_i = 0; m_eos = 1;
    chk_irq("R9 eos irq");
    rd_stat("R8 eos", 0);
    rd_stat("R7 eos cleared", 1);
    rd_stat("R7 eos kept", 0);
    chk_irq("R9 eos gone");

    // R10 clear mid-sample
    push(16'h1234); push(16'h5678);
    rd_data("R10 low");
    push(16'h9abc);
    fifo_clr();
    rd_stat("R10 cleared", 0);
    push(16'hC3E1);
    rd_data("R10 phase reset low");
    rd_data("R10 phase reset high");

    // R11 running
    running_i = 1;
    rd_stat("R11 running", 0);
    running_i = 0;
    rd_stat("R11 idle", 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule